// File: doc/BRIEF.md
# Control-Transfer Resolver

This block sits at the execute stage of a 32-bit integer pipeline. Each cycle it can accept one decoded instruction word with its program counter and two register operands. When the word is a conditional branch, a direct jump or a register-indirect jump, the block works out the next fetch address and whether fetch must be redirected. Any other word resolves to the sequential address.

The offsets are stored in the instruction in scrambled bit order. The block puts them back together before it adds them. Whenever it loads the program counter instead of incrementing it, it raises a one-cycle flush pulse so that younger stages can drop the work they have already fetched. A target whose low two bits are not zero is flagged alongside the redirect. Both jump forms also produce a link write of the return address.

All results are registered and appear one clock after the instruction is presented.

Top module: `ctl_xfer_resolve`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every output is zero.
- R2: A word with opcode bits [6:0] = 1100011 is a conditional branch, and bits [14:12] choose the test on `src_a` against `src_b`. The codes are 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less and 111 unsigned greater-or-equal. When the test holds, `next_pc` is `pc` plus the branch offset.
- R3: The branch offset is sign-extended from word bit 31 as offset bit 12. Word bit 7 supplies offset bit 11, word bits 30:25 supply offset bits 10:5, word bits 11:8 supply offset bits 4:1, and offset bit 0 is zero.
- R4: A branch whose test fails gives `next_pc` = `pc` + 4 with no flush.
- R5: Opcode 1101111 always redirects to `pc` plus the jump offset. That offset is sign-extended from word bit 31 as bit 20, with bits 19:12 from word bits 19:12, bit 11 from word bit 20, bits 10:1 from word bits 30:21, and bit 0 zero.
- R6: Opcode 1100111 with bits [14:12] = 000 always redirects to `src_a` plus the sign-extended word bits 31:20, with bit 0 of the sum forced to zero.
- R7: `flush` is high for exactly one cycle for each redirecting instruction, one cycle after it is presented, and it is low in every other cycle.
- R8: `misalign` is high exactly when a redirect's target has a nonzero value in bits [1:0].
- R9: Both jump forms raise `link_we`, with `link_rd` = word bits 11:7 and `link_data` = `pc` + 4. When bits 11:7 are zero, `link_we` stays low.
- R10: Any other word resolves to `pc` + 4 with no flush, no link and no misalign. This includes a branch opcode with test code 010 or 011 and the register-jump opcode with a nonzero bits [14:12].
- R11: `res_valid` follows `in_valid` one cycle later, and nothing is reported in a cycle where no instruction was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| src_a | input | XLEN | First register operand |
| src_b | input | XLEN | Second register operand |
| res_valid | output | 1 | Result of last cycle's instruction is valid |
| flush | output | 1 | Redirect pulse; younger stages discard |
| next_pc | output | XLEN | Next fetch address |
| misalign | output | 1 | Redirect target not word aligned |
| link_we | output | 1 | Return-address write enable |
| link_rd | output | RIDX_W | Return-address destination register |
| link_data | output | XLEN | Return address, pc + 4 |

## Verification
A fault in offset reassembly shows up as a wrong `next_pc` on the very next cycle, and only for offsets that have the affected bits set. For this reason the stimulus isolates each scattered field: offset bit 11, the upper jump bits and the low bits. A wrong comparison choice flips `flush` and `next_pc` between the taken and sequential values. The operand pairs are chosen so that the signed and unsigned orderings disagree, which makes such a fault visible. Stuck or stretched pulse logic shows up as `flush` being high in an idle cycle or missing from one of two back-to-back jumps.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam logic [6:0] OPC_COND = 7'b1100011;
  localparam logic [6:0] OPC_JDIR = 7'b1101111;
  localparam logic [6:0] OPC_JREG = 7'b1100111;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'b000,
    CMP_NE  = 3'b001,
    CMP_LT  = 3'b100,
    CMP_GE  = 3'b101,
    CMP_LTU = 3'b110,
    CMP_GEU = 3'b111
  } cmp_code_e;
endpackage

// File: rtl/xfer_imm.sv
// Rebuilds the three sign-extended offsets from the upper instruction bits.
module xfer_imm #(
  parameter int XLEN = 32
) (
  input  logic [31:7]     hi,
  output logic [XLEN-1:0] off_cond,
  output logic [XLEN-1:0] off_jdir,
  output logic [XLEN-1:0] off_jreg
);
  localparam int CPAD = XLEN - 13;
  localparam int JPAD = XLEN - 21;
  localparam int IPAD = XLEN - 12;

  always_comb begin
    off_cond = {{CPAD{hi[31]}}, hi[31], hi[7], hi[30:25], hi[11:8], 1'b0};
    off_jdir = {{JPAD{hi[31]}}, hi[31], hi[19:12], hi[20], hi[30:21], 1'b0};
    off_jreg = {{IPAD{hi[31]}}, hi[31:20]};
  end
endmodule

// File: rtl/xfer_cmp.sv
// Evaluates the conditional-branch test; flags codes with no defined test.
module xfer_cmp import xfer_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      code,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            hold,
  output logic            known
);
  logic eq, lt_s, lt_u;

  always_comb begin
    eq   = (a == b);
    lt_s = ($signed(a) < $signed(b));
    lt_u = (a < b);
    known = 1'b1;
    case (cmp_code_e'(code))
      CMP_EQ:  hold = eq;
      CMP_NE:  hold = !eq;
      CMP_LT:  hold = lt_s;
      CMP_GE:  hold = !lt_s;
      CMP_LTU: hold = lt_u;
      CMP_GEU: hold = !lt_u;
      default: begin
        hold  = 1'b0;
        known = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ctl_xfer_resolve.sv
module ctl_xfer_resolve import xfer_pkg::*; #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  output logic              res_valid,
  output logic              flush,
  output logic [XLEN-1:0]   next_pc,
  output logic              misalign,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_rd,
  output logic [XLEN-1:0]   link_data
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

  logic [XLEN-1:0]   off_cond, off_jdir, off_jreg;
  logic              cond_hold, cond_known;
  logic [6:0]        opc;
  logic [2:0]        fn;
  logic [RIDX_W-1:0] dst;
  logic              is_cond, is_jdir, is_jreg, take;
  logic [XLEN-1:0]   seq_pc, tgt, jreg_sum;

  xfer_imm #(.XLEN(XLEN)) u_imm (
    .hi(instr[31:7]), .off_cond(off_cond), .off_jdir(off_jdir), .off_jreg(off_jreg)
  );

  xfer_cmp #(.XLEN(XLEN)) u_cmp (
    .code(instr[14:12]), .a(src_a), .b(src_b), .hold(cond_hold), .known(cond_known)
  );

  always_comb begin
    opc      = instr[6:0];
    fn       = instr[14:12];
    dst      = instr[7 +: RIDX_W];
    is_cond  = (opc == OPC_COND) && cond_known;
    is_jdir  = (opc == OPC_JDIR);
    is_jreg  = (opc == OPC_JREG) && (fn == 3'b000);
    take     = is_jdir || is_jreg || (is_cond && cond_hold);
    seq_pc   = pc + STEP;
    jreg_sum = src_a + off_jreg;
    if (is_jreg)      tgt = jreg_sum & LSB_CLR;
    else if (is_jdir) tgt = pc + off_jdir;
    else              tgt = pc + off_cond;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      flush     <= 1'b0;
      next_pc   <= '0;
      misalign  <= 1'b0;
      link_we   <= 1'b0;
      link_rd   <= '0;
      link_data <= '0;
    end else begin
      res_valid <= in_valid;
      flush     <= in_valid && take;
      misalign  <= in_valid && take && (tgt[1:0] != 2'b00);
      link_we   <= in_valid && (is_jdir || is_jreg) && (dst != '0);
      if (in_valid) begin
        next_pc   <= take ? tgt : seq_pc;
        link_rd   <= dst;
        link_data <= seq_pc;
      end
    end
  end
endmodule

// File: rtl/ctl_xfer_resolve_chk.sv
module ctl_xfer_resolve_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [XLEN-1:0]   pc,
  input logic              res_valid,
  input logic              flush,
  input logic [XLEN-1:0]   next_pc,
  input logic              misalign,
  input logic              link_we,
  input logic [RIDX_W-1:0] link_rd,
  input logic [XLEN-1:0]   link_data
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !flush && !link_we && !misalign));

  p_flush_has_result_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> res_valid);

  p_seq_addr_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flush || next_pc == $past(pc) + XLEN'(4)));

  p_jdir_redirects_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[6:0] == 7'b1101111) |=> flush);

  p_jreg_even_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[6:0] == 7'b1100111 && instr[14:12] == 3'b000) |=> (flush && !next_pc[0]));

  p_misalign_r8: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (flush && next_pc[1:0] != 2'b00));

  p_link_r9: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_rd != '0 && link_data == $past(pc) + XLEN'(4)));
endmodule

bind ctl_xfer_resolve ctl_xfer_resolve_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
  .res_valid(res_valid), .flush(flush), .next_pc(next_pc), .misalign(misalign),
  .link_we(link_we), .link_rd(link_rd), .link_data(link_data)
);

// File: tb/ctl_xfer_resolve_tb_top.sv
module ctl_xfer_resolve_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, pc = '0, src_a = '0, src_b = '0;
  logic        res_valid, flush, misalign, link_we;
  logic [31:0] next_pc, link_data;
  logic [4:0]  link_rd;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic        redir;
    logic [31:0] npc;
    logic        mis;
    logic        lwe;
    logic [4:0]  lrd;
    logic [31:0] ldata;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  ctl_xfer_resolve dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .flush(flush),
    .next_pc(next_pc), .misalign(misalign), .link_we(link_we),
    .link_rd(link_rd), .link_data(link_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_cond(logic [2:0] f3, logic [31:0] off);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_jdir(logic [4:0] rd, logic [31:0] off);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_jreg(logic [2:0] f3, logic [4:0] rd, logic [11:0] imm);
    return {imm, 5'd1, f3, rd, 7'b1100111};
  endfunction

  task automatic push(logic [31:0] w, logic [31:0] p, logic [31:0] a, logic [31:0] b, exp_t e);
    @(negedge clk);
    in_valid = 1'b1; instr = w; pc = p; src_a = a; src_b = b;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; instr = $urandom; pc = $urandom;
  endtask

  task automatic send_cond(string tag, logic [2:0] f3, logic [31:0] off, logic [31:0] p,
                           logic [31:0] a, logic [31:0] b);
    exp_t e;
    logic t;
    case (f3)
      3'b000: t = (a == b);
      3'b001: t = (a != b);
      3'b100: t = ($signed(a) < $signed(b));
      3'b101: t = ($signed(a) >= $signed(b));
      3'b110: t = (a < b);
      default: t = (a >= b);
    endcase
    e.redir = t; e.npc = t ? p + off : p + 4;
    e.mis = t && ((p + off) & 3) != 0;
    e.lwe = 1'b0; e.lrd = 5'd0; e.ldata = p + 4; e.tag = tag;
    push(enc_cond(f3, off), p, a, b, e);
  endtask

  task automatic send_jdir(string tag, logic [4:0] rd, logic [31:0] off, logic [31:0] p);
    exp_t e;
    e.redir = 1'b1; e.npc = p + off; e.mis = ((p + off) & 3) != 0;
    e.lwe = (rd != 0); e.lrd = rd; e.ldata = p + 4; e.tag = tag;
    push(enc_jdir(rd, off), p, 32'h0, 32'h0, e);
  endtask

  task automatic send_jreg(string tag, logic [4:0] rd, logic [31:0] imm, logic [31:0] p,
                           logic [31:0] a);
    exp_t e;
    logic [31:0] s;
    s = (a + imm) & 32'hFFFF_FFFE;
    e.redir = 1'b1; e.npc = s; e.mis = (s & 3) != 0;
    e.lwe = (rd != 0); e.lrd = rd; e.ldata = p + 4; e.tag = tag;
    push(enc_jreg(3'b000, rd, imm[11:0]), p, a, 32'h0, e);
  endtask

  task automatic send_other(string tag, logic [31:0] w, logic [31:0] p);
    exp_t e;
    e.redir = 1'b0; e.npc = p + 4; e.mis = 1'b0;
    e.lwe = 1'b0; e.lrd = w[11:7]; e.ldata = p + 4; e.tag = tag;
    push(w, p, 32'h5, 32'h9, e);
  endtask

  // Monitor: results appear on the edge after capture; sample 2 ns later.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst) begin
        if (res_valid) begin
          if (sb.size() == 0) begin
            check("R11 unexpected result", 32'd1, 32'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " R7 flush"}, 32'(flush), 32'(e.redir));
            check({e.tag, " next_pc"}, next_pc, e.npc);
            check({e.tag, " R8 misalign"}, 32'(misalign), 32'(e.mis));
            check({e.tag, " R9 link_we"}, 32'(link_we), 32'(e.lwe));
            if (e.lwe) begin
              check({e.tag, " R9 link_rd"}, 32'(link_rd), 32'(e.lrd));
              check({e.tag, " R9 link_data"}, link_data, e.ldata);
            end
          end
        end else begin
          check("R7 idle flush", 32'(flush), 32'd0);
          check("R11 idle link_we", 32'(link_we), 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 flush", 32'(flush), 32'd0);
    check("R1 next_pc", next_pc, 32'd0);
    check("R1 link_we", 32'(link_we), 32'd0);
    check("R1 misalign", 32'(misalign), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2/R3/R4: every test code, taken and not taken, scattered offset bits
    send_cond("R2 R3 eq taken neg", 3'b000, 32'hFFFF_FFFC, 32'h1000, 32'd5, 32'd5);
    send_cond("R4 eq not taken", 3'b000, 32'h0000_0010, 32'h1000, 32'd5, 32'd6);
    send_cond("R3 ne taken bit11", 3'b001, 32'h0000_0800, 32'h1000, 32'd5, 32'd6);
    send_cond("R4 ne not taken", 3'b001, 32'h0000_0800, 32'h1000, 32'd7, 32'd7);
    send_cond("R2 R3 lt signed taken max", 3'b100, 32'h0000_0FFE, 32'h1000, 32'hFFFF_FFFF, 32'd1);
    send_cond("R2 ltu not taken", 3'b110, 32'h0000_0100, 32'h1000, 32'hFFFF_FFFF, 32'd1);
    send_cond("R2 ge signed not taken", 3'b101, 32'h0000_0100, 32'h1000, 32'hFFFF_FFFF, 32'd1);
    send_cond("R2 R3 ge equal taken min", 3'b101, 32'hFFFF_F000, 32'h1_0000, 32'd1, 32'd1);
    send_cond("R2 R3 geu taken mid bits", 3'b111, 32'h0000_07E0, 32'h1000, 32'hFFFF_FFFF, 32'd1);
    send_cond("R2 R8 ltu taken low bits", 3'b110, 32'h0000_001E, 32'h1000, 32'd1, 32'hFFFF_FFFF);
    idle();

    // R5/R9: direct jumps
    send_jdir("R5 bit11", 5'd1, 32'h0000_0800, 32'h2000);
    send_jdir("R5 min neg", 5'd5, 32'hFFF0_0000, 32'h2000);
    send_jdir("R5 R9 upper bits rd0", 5'd0, 32'h000F_F000, 32'h2000);
    send_jdir("R5 R8 misaligned", 5'd31, 32'h0000_03FE, 32'h2000);
    idle();
    idle();

    // R6/R9: register jumps
    send_jreg("R6 odd sum cleared", 5'd3, 32'h0000_0004, 32'h3000, 32'h0000_3001);
    send_jreg("R6 R9 neg imm rd0", 5'd0, 32'hFFFF_F800, 32'h3000, 32'h0000_1010);
    send_jreg("R6 R8 misaligned", 5'd7, 32'h0000_0002, 32'h3000, 32'h0000_0100);
    idle();

    // R10: words that are not control transfers
    send_other("R10 alu op", 32'h0020_80B3, 32'h4000);
    send_other("R10 cond code 010", enc_cond(3'b010, 32'h40), 32'h4000);
    send_other("R10 cond code 011", enc_cond(3'b011, 32'h40), 32'h4000);
    send_other("R10 jreg code 001", enc_jreg(3'b001, 5'd4, 12'h010), 32'h4000);
    idle();
    idle();
    idle();
    check("R11 all results seen", 32'(sb.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule